// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for software profiling. It holds a small bank of general event counters and one dedicated cycle counter. Each event counter picks the event it counts through its own type register. The event inputs are one pulse line per event type. The cycle counter advances on a tick input. Software controls and reads everything through a flat register port with an address, a write strobe, write data and combinational read data.

All counters sit in one 32-entry index space. Index 31 is always the cycle counter, and indices 0 to NUM_CTR-1 are the event counters. The same index is the bit position in the count-enable, interrupt-enable and overflow masks. A selection register picks one index, which can then be reached through an indirect value register and an indirect type register.

When a counter wraps, its overflow flag is set. The single level interrupt stays high while any overflow flag has its interrupt enabled.

Register word addresses:

| Address | Register |
|---|---|
| 0x00 | control |
| 0x01 | count-enable set |
| 0x02 | count-enable clear |
| 0x03 | interrupt-enable set |
| 0x04 | interrupt-enable clear |
| 0x05 | overflow set |
| 0x06 | overflow clear |
| 0x07 | software increment |
| 0x08 | selection |
| 0x09 | indirect value |
| 0x0A | indirect type |
| 0x20+i | value of counter i |
| 0x40+i | type of counter i |

Every other address reads zero.

Top module: `perf_mon_unit`

## Requirements
- R1: Control register, address 0x00.
  - Only bits 0 (global enable), 3 (divide-by-64), 4 and 5 keep written values.
  - Bits 1, 2 and 6 read 0.
  - Bits 15:11 read NUM_CTR, bits 23:16 read ID_CODE (reset 0x3C) and bits 31:24 read IMP_CODE (0xA5).
  - After reset the register reads 0xA53C2000.
- R2: Event counter i advances by one on each clock edge at which all of the following hold:
  - control bit 0 is set;
  - count-enable bit i is set;
  - the event line selected by its type is high.
  Event number k, in type bits 15:0, from 1 to NUM_EVT selects line k-1.
- R3: A counter that advances from all ones wraps to zero and sets its overflow flag. The flag is bit i for an event counter and bit 31 for the cycle counter.
- R4: Writing control bit 1 clears every event counter to zero and leaves the cycle counter unchanged.
- R5: Cycle counter behaviour.
  - It advances once per tick while control bit 0 and count-enable bit 31 are set.
  - With control bit 3 set, it advances once per 64 such ticks.
  - Writing control bit 2 clears both the counter and the tick remainder.
- R6: The set and clear registers of the count-enable, interrupt-enable and overflow masks behave as follows.
  - Writing a 1 to a bit sets or clears that bit.
  - Any of the paired addresses reads back the current mask.
  - Bits of nonexistent counters stay 0.
- R7: irq_o is high exactly while the overflow mask AND the interrupt-enable mask is nonzero. It follows set and clear writes of either mask from the next clock edge.
- R8: For an index from NUM_CTR to 30, the value and type registers read 0, and writes to them change nothing.
- R9: Writing a 1 to bit i of the software-increment register (0x07) adds one to event counter i if it is enabled as in R2 and its event number is 0.
- R10: Type registers.
  - An event counter's type register keeps bits 15:0 (event number) and bits 31:26 (filter). All other bits read 0.
  - The cycle counter's type register keeps only bits 31:26.
  - The filter bits are stored and have no effect on counting.
- R11: Selection register, address 0x08.
  - It keeps its low 5 bits.
  - The indirect value (0x09) and indirect type (0x0A) registers access the selected index. Index 31 reaches the cycle counter and its filter register.
- R12: A write to a counter value loads that value. The write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| reg_addr_i | input | 7 | register word address |
| reg_we_i | input | 1 | register write strobe |
| reg_wdata_i | input | CTR_W | register write data |
| reg_rdata_o | output | CTR_W | register read data, combinational from address |
| evt_i | input | NUM_EVT | event lines, sampled at each clock edge |
| tick_i | input | 1 | cycle-counter tick |
| irq_o | output | 1 | overflow interrupt, level |

## Verification
The assertions assume that all inputs are settled before each rising edge. They also assume that a write reaches only the register decoded from its address, so at most one mask strobe is active per cycle. The interrupt property excludes the cycle in which the interrupt enable is being cleared, because that write may legally drop the line.

The bench drives every input on the falling edge, one write at a time. It holds event lines high for single cycles, except in the one test that deliberately combines a write with a pulse. A behavioural model tracks every register and is compared with the interrupt line on every cycle and with read data after each step.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int unsigned IDX_W   = 5;
    localparam int unsigned CYC_IDX = 31;

    // register word addresses in the miscellaneous bank
    localparam logic [6:0] A_CTRL    = 7'h00;
    localparam logic [6:0] A_CEN_SET = 7'h01;
    localparam logic [6:0] A_CEN_CLR = 7'h02;
    localparam logic [6:0] A_IEN_SET = 7'h03;
    localparam logic [6:0] A_IEN_CLR = 7'h04;
    localparam logic [6:0] A_OVF_SET = 7'h05;
    localparam logic [6:0] A_OVF_CLR = 7'h06;
    localparam logic [6:0] A_SWINC   = 7'h07;
    localparam logic [6:0] A_SEL     = 7'h08;
    localparam logic [6:0] A_IVAL    = 7'h09;
    localparam logic [6:0] A_ITYP    = 7'h0A;

    // address bank, taken from address bits 6:5
    typedef enum logic [1:0] {
        BANK_MISC = 2'b00,
        BANK_VAL  = 2'b01,
        BANK_TYP  = 2'b10,
        BANK_NONE = 2'b11
    } pmc_bank_e;

    // control bit positions
    localparam int unsigned CB_ENABLE  = 0;
    localparam int unsigned CB_EVT_RST = 1;
    localparam int unsigned CB_CYC_RST = 2;
    localparam int unsigned CB_DIV64   = 3;

    localparam logic [5:0] CTRL_KEEP = 6'h39;

endpackage

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr #(
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned NUM_EVT = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               sw_hit_i,
    input  logic               clr_i,
    input  logic               val_we_i,
    input  logic               typ_we_i,
    input  logic [CTR_W-1:0]   wdata_i,
    input  logic [21:0]        typ_wdata_i,   // {filter[5:0], event[15:0]}
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [CTR_W-1:0]   val_o,
    output logic [31:0]        typ_o,
    output logic               wrap_o
);

    logic [CTR_W-1:0] val_q;
    logic [15:0]      evt_q;
    logic [5:0]       flt_q;
    logic             ev_hit;
    logic             inc;

    always_comb begin
        ev_hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (evt_q == 16'(k + 1) && evt_i[k]) ev_hit = 1'b1;
        end
        if (evt_q == 16'd0) ev_hit = sw_hit_i;
    end

    assign inc    = run_i && ev_hit && !clr_i && !val_we_i;
    assign wrap_o = inc && (val_q == {CTR_W{1'b1}});

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            val_q <= '0;
            evt_q <= '0;
            flt_q <= '0;
        end else begin
            if (clr_i)         val_q <= '0;
            else if (val_we_i) val_q <= wdata_i;
            else if (inc)      val_q <= val_q + 1'b1;
            if (typ_we_i) begin
                evt_q <= typ_wdata_i[15:0];
                flt_q <= typ_wdata_i[21:16];
            end
        end
    end

    assign val_o = val_q;
    assign typ_o = {flt_q, 10'd0, evt_q};

    a_r4_evt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (val_o == '0));

    a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !val_we_i && !(run_i && ev_hit)) |=> $stable(val_o));

endmodule

// File: rtl/pmc_cycle_ctr.sv
module pmc_cycle_ctr #(
    parameter int unsigned CTR_W    = 32,
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             div_i,
    input  logic             clr_i,
    input  logic             val_we_i,
    input  logic             flt_we_i,
    input  logic [CTR_W-1:0] wdata_i,
    input  logic [5:0]       flt_wdata_i,
    output logic [CTR_W-1:0] val_o,
    output logic [31:0]      flt_o,
    output logic             wrap_o
);

    logic [CTR_W-1:0]    val_q;
    logic [DIV_LOG2-1:0] rem_q;
    logic [5:0]          flt_q;
    logic                live;
    logic                step;

    assign live   = run_i && tick_i && !clr_i && !val_we_i;
    assign step   = live && (!div_i || rem_q == {DIV_LOG2{1'b1}});
    assign wrap_o = step && (val_q == {CTR_W{1'b1}});

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            val_q <= '0;
            rem_q <= '0;
            flt_q <= '0;
        end else begin
            if (clr_i) begin
                val_q <= '0;
                rem_q <= '0;
            end else if (val_we_i) begin
                val_q <= wdata_i;
            end else begin
                if (live && div_i) rem_q <= rem_q + 1'b1;
                if (step)          val_q <= val_q + 1'b1;
            end
            if (flt_we_i) flt_q <= flt_wdata_i;
        end
    end

    assign val_o = val_q;
    assign flt_o = {flt_q, 26'd0};

    a_r5_cyc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (val_o == '0));

    a_r5_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_i && rem_q != {DIV_LOG2{1'b1}} && !clr_i && !val_we_i) |=> $stable(val_o));

endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
    parameter int unsigned NUM_CTR = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cen_set_i,
    input  logic        cen_clr_i,
    input  logic        ien_set_i,
    input  logic        ien_clr_i,
    input  logic        ovf_set_i,
    input  logic        ovf_clr_i,
    input  logic [31:0] wmask_i,
    input  logic [31:0] wrap_i,
    output logic [31:0] cen_o,
    output logic [31:0] ien_o,
    output logic [31:0] ovf_o,
    output logic        irq_o
);

    localparam logic [31:0] LIVE = 32'h8000_0000 | 32'((64'd1 << NUM_CTR) - 64'd1);

    logic [31:0] cen_q;
    logic [31:0] ien_q;
    logic [31:0] ovf_q;
    logic [31:0] ovf_setm;
    logic [31:0] ovf_clrm;

    assign ovf_setm = ovf_set_i ? (wmask_i & LIVE) : 32'd0;
    assign ovf_clrm = ovf_clr_i ? wmask_i : 32'd0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cen_q <= '0;
            ien_q <= '0;
            ovf_q <= '0;
        end else begin
            if (cen_set_i)      cen_q <= cen_q | (wmask_i & LIVE);
            else if (cen_clr_i) cen_q <= cen_q & ~wmask_i;
            if (ien_set_i)      ien_q <= ien_q | (wmask_i & LIVE);
            else if (ien_clr_i) ien_q <= ien_q & ~wmask_i;
            // a wrap in the same cycle wins over a clear
            ovf_q <= ((ovf_q | ovf_setm) & ~ovf_clrm) | wrap_i;
        end
    end

    assign cen_o = cen_q;
    assign ien_o = ien_q;
    assign ovf_o = ovf_q;
    assign irq_o = |(ovf_q & ien_q);

    a_r7_irq_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|(wrap_i & ien_q)) && !ien_clr_i) |=> irq_o);

    a_r3_wrap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|wrap_i) |=> ((ovf_q & $past(wrap_i)) == $past(wrap_i)));

    a_r6_enable_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cen_clr_i |=> ((cen_q & $past(wmask_i)) == 32'd0));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmc_pkg::*;
#(
    parameter int unsigned NUM_CTR  = 4,
    parameter int unsigned NUM_EVT  = 8,
    parameter int unsigned CTR_W    = 32,
    parameter logic [7:0]  IMP_CODE = 8'hA5,
    parameter logic [7:0]  ID_CODE  = 8'h3C
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [6:0]         reg_addr_i,
    input  logic               reg_we_i,
    input  logic [CTR_W-1:0]   reg_wdata_i,
    output logic [CTR_W-1:0]   reg_rdata_o,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               tick_i,
    output logic               irq_o
);

    localparam int unsigned SLOTS = 2 ** IDX_W;

    logic [5:0]       ctrl_q;
    logic [IDX_W-1:0] sel_q;
    logic [31:0]      wlo;
    logic [31:0]      cen;
    logic [31:0]      ien;
    logic [31:0]      ovf;
    logic [31:0]      wrap_all;
    logic [31:0]      ctrl_rd;
    logic             wr_ctrl;
    logic             wr_swinc;
    logic             ge;
    pmc_bank_e        bank;
    logic [IDX_W-1:0] idx;

    logic [CTR_W-1:0] ev_val  [NUM_CTR];
    logic [31:0]      ev_typ  [NUM_CTR];
    logic [NUM_CTR-1:0] ev_wrap;
    logic [CTR_W-1:0] cyc_val;
    logic [31:0]      cyc_flt;
    logic             cyc_wrap;
    logic [CTR_W-1:0] val_all [SLOTS];
    logic [31:0]      typ_all [SLOTS];
    logic [SLOTS-1:0] val_we;
    logic [SLOTS-1:0] typ_we;

    assign wlo      = reg_wdata_i[31:0];
    assign bank     = pmc_bank_e'(reg_addr_i[6:5]);
    assign idx      = reg_addr_i[4:0];
    assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
    assign wr_swinc = reg_we_i && (reg_addr_i == A_SWINC);
    assign ge       = ctrl_q[CB_ENABLE];

    // write strobes for every index, direct or through the selection
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            val_we[j] = reg_we_i && ((bank == BANK_VAL && idx == IDX_W'(j)) ||
                                     (reg_addr_i == A_IVAL && sel_q == IDX_W'(j)));
            typ_we[j] = reg_we_i && ((bank == BANK_TYP && idx == IDX_W'(j)) ||
                                     (reg_addr_i == A_ITYP && sel_q == IDX_W'(j)));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wlo[5:0] & CTRL_KEEP;
            if (reg_we_i && reg_addr_i == A_SEL) sel_q <= wlo[IDX_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
        pmc_event_ctr #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT)
        ) u_ctr (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .run_i       (ge && cen[i]),
            .sw_hit_i    (wr_swinc && wlo[i]),
            .clr_i       (wr_ctrl && wlo[CB_EVT_RST]),
            .val_we_i    (val_we[i]),
            .typ_we_i    (typ_we[i]),
            .wdata_i     (reg_wdata_i),
            .typ_wdata_i ({wlo[31:26], wlo[15:0]}),
            .evt_i       (evt_i),
            .val_o       (ev_val[i]),
            .typ_o       (ev_typ[i]),
            .wrap_o      (ev_wrap[i])
        );
    end

    pmc_cycle_ctr #(
        .CTR_W    (CTR_W),
        .DIV_LOG2 (6)
    ) u_cyc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (ge && cen[CYC_IDX]),
        .tick_i      (tick_i),
        .div_i       (ctrl_q[CB_DIV64]),
        .clr_i       (wr_ctrl && wlo[CB_CYC_RST]),
        .val_we_i    (val_we[CYC_IDX]),
        .flt_we_i    (typ_we[CYC_IDX]),
        .wdata_i     (reg_wdata_i),
        .flt_wdata_i (wlo[31:26]),
        .val_o       (cyc_val),
        .flt_o       (cyc_flt),
        .wrap_o      (cyc_wrap)
    );

    always_comb begin
        wrap_all = '0;
        for (int j = 0; j < NUM_CTR; j++) wrap_all[j] = ev_wrap[j];
        wrap_all[CYC_IDX] = cyc_wrap;
    end

    pmc_status #(
        .NUM_CTR (NUM_CTR)
    ) u_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cen_set_i (reg_we_i && reg_addr_i == A_CEN_SET),
        .cen_clr_i (reg_we_i && reg_addr_i == A_CEN_CLR),
        .ien_set_i (reg_we_i && reg_addr_i == A_IEN_SET),
        .ien_clr_i (reg_we_i && reg_addr_i == A_IEN_CLR),
        .ovf_set_i (reg_we_i && reg_addr_i == A_OVF_SET),
        .ovf_clr_i (reg_we_i && reg_addr_i == A_OVF_CLR),
        .wmask_i   (wlo),
        .wrap_i    (wrap_all),
        .cen_o     (cen),
        .ien_o     (ien),
        .ovf_o     (ovf),
        .irq_o     (irq_o)
    );

    // index space view: absent indices read zero
    for (genvar j = 0; j < SLOTS; j++) begin : g_map
        if (j == CYC_IDX) begin : g_cyc
            assign val_all[j] = cyc_val;
            assign typ_all[j] = cyc_flt;
        end else if (j < NUM_CTR) begin : g_ev
            assign val_all[j] = ev_val[j];
            assign typ_all[j] = ev_typ[j];
        end else begin : g_none
            assign val_all[j] = '0;
            assign typ_all[j] = '0;
        end
    end

    // bit 6 (long overflow) is not writable and reads zero
    assign ctrl_rd = {IMP_CODE, ID_CODE, 5'(NUM_CTR), 4'd0, 1'b0, ctrl_q};

    always_comb begin
        reg_rdata_o = '0;
        unique case (bank)
            BANK_VAL:  reg_rdata_o = val_all[idx];
            BANK_TYP:  reg_rdata_o = CTR_W'(typ_all[idx]);
            BANK_MISC: begin
                case (reg_addr_i)
                    A_CTRL:               reg_rdata_o = CTR_W'(ctrl_rd);
                    A_CEN_SET, A_CEN_CLR: reg_rdata_o = CTR_W'(cen);
                    A_IEN_SET, A_IEN_CLR: reg_rdata_o = CTR_W'(ien);
                    A_OVF_SET, A_OVF_CLR: reg_rdata_o = CTR_W'(ovf);
                    A_SEL:                reg_rdata_o = CTR_W'(sel_q);
                    A_IVAL:               reg_rdata_o = val_all[sel_q];
                    A_ITYP:               reg_rdata_o = CTR_W'(typ_all[sel_q]);
                    default:              reg_rdata_o = '0;
                endcase
            end
            BANK_NONE: reg_rdata_o = '0;
        endcase
    end

    a_r1_ctrl_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ctrl |=> (ctrl_q[2:1] == 2'b00));

endmodule

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  evt = '0;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .evt_i       (evt),
        .tick_i      (tick),
        .irq_o       (irq)
    );

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] M_LIVE = 32'h8000_000F;
    logic [31:0] m_val [32];
    logic [31:0] m_typ [32];
    logic [31:0] m_cen, m_ien, m_ovf, m_wraps;
    logic [5:0]  m_ctrl;
    logic [4:0]  m_sel;
    int          m_rem;
    int          wv, wt;
    bit          inc;
    int          en;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin m_val[i] = 0; m_typ[i] = 0; end
            m_cen = 0; m_ien = 0; m_ovf = 0; m_ctrl = 0; m_sel = 0; m_rem = 0;
        end else begin
            m_wraps = 0;
            wv = -1; wt = -1;
            if (we && addr >= 7'h20 && addr < 7'h40) wv = addr - 7'h20;
            if (we && addr == 7'h09) wv = m_sel;
            if (we && addr >= 7'h40 && addr < 7'h60) wt = addr - 7'h40;
            if (we && addr == 7'h0A) wt = m_sel;
            for (int i = 0; i < 4; i++) begin
                en = m_typ[i][15:0];
                if (en == 0) inc = we && addr == 7'h07 && wdata[i];
                else inc = (en <= 8) && evt[en-1];
                if (we && addr == 7'h00 && wdata[1]) m_val[i] = 0;
                else if (wv == i) m_val[i] = wdata;
                else if (m_ctrl[0] && m_cen[i] && inc) begin
                    if (m_val[i] == 32'hFFFF_FFFF) m_wraps[i] = 1'b1;
                    m_val[i] = m_val[i] + 1;
                end
            end
            if (we && addr == 7'h00 && wdata[2]) begin m_val[31] = 0; m_rem = 0; end
            else if (wv == 31) m_val[31] = wdata;
            else if (m_ctrl[0] && m_cen[31] && tick) begin
                inc = 1;
                if (m_ctrl[3]) begin
                    inc = (m_rem == 63);
                    m_rem = (m_rem + 1) % 64;
                end
                if (inc) begin
                    if (m_val[31] == 32'hFFFF_FFFF) m_wraps[31] = 1'b1;
                    m_val[31] = m_val[31] + 1;
                end
            end
            if (wt >= 0 && wt < 4) m_typ[wt] = wdata & 32'hFC00_FFFF;
            if (wt == 31) m_typ[31] = wdata & 32'hFC00_0000;
            if (we) begin
                case (addr)
                    7'h00: m_ctrl = wdata[5:0] & 6'h39;
                    7'h01: m_cen = m_cen | (wdata & M_LIVE);
                    7'h02: m_cen = m_cen & ~wdata;
                    7'h03: m_ien = m_ien | (wdata & M_LIVE);
                    7'h04: m_ien = m_ien & ~wdata;
                    7'h05: m_ovf = m_ovf | (wdata & M_LIVE);
                    7'h06: m_ovf = m_ovf & ~wdata;
                    7'h08: m_sel = wdata[4:0];
                    default: ;
                endcase
            end
            m_ovf = m_ovf | m_wraps;
        end
    end

    function automatic logic [31:0] m_read(input logic [6:0] a);
        if (a >= 7'h20 && a < 7'h40) return m_val[a - 7'h20];
        if (a >= 7'h40 && a < 7'h60) return m_typ[a - 7'h40];
        case (a)
            7'h00: return {8'hA5, 8'h3C, 5'd4, 4'd0, 1'b0, m_ctrl};
            7'h01, 7'h02: return m_cen;
            7'h03, 7'h04: return m_ien;
            7'h05, 7'h06: return m_ovf;
            7'h08: return {27'd0, m_sel};
            7'h09: return m_val[m_sel];
            7'h0A: return m_typ[m_sel];
            default: return 32'd0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // interrupt compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) chk("R7 irq per cycle", {31'd0, irq}, {31'd0, |(m_ovf & m_ien)});
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_model(input logic [6:0] a, input string tag);
        addr = a; #1;
        chk(tag, rdata, m_read(a));
    endtask

    task automatic rd_exp(input logic [6:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
        chk({tag, " model"}, rdata, m_read(a));
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            evt = m; @(negedge clk); evt = '0; @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset and write masking
        rd_exp(7'h00, 32'hA53C_2000, "R1 reset ctrl");
        chk("R7 reset irq", {31'd0, irq}, 32'd0);
        wr(7'h00, 32'h0000_00FF);
        rd_exp(7'h00, 32'hA53C_2039, "R1 masked ctrl write");
        wr(7'h00, 32'h0000_0001);

        // R10 type registers
        wr(7'h40, 32'h0000_0003);
        wr(7'h41, 32'h0000_0001);
        wr(7'h42, 32'h0000_0000);
        wr(7'h43, 32'hFFFF_0005);
        rd_exp(7'h43, 32'hFC00_0005, "R10 type mask");
        wr(7'h5F, 32'hFFFF_FFFF);
        rd_exp(7'h5F, 32'hFC00_0000, "R10 cycle filter");

        // R6 enables
        wr(7'h01, 32'h8000_0007);
        wr(7'h01, 32'h0000_0F00);
        rd_exp(7'h02, 32'h8000_0007, "R6 enable mask");

        // R2 counting
        pulse(8'h04, 3);
        pulse(8'h01, 2);
        pulse(8'h10, 2);
        rd_exp(7'h20, 32'd3, "R2 ctr0 line2");
        rd_exp(7'h21, 32'd2, "R2 ctr1 line0");
        rd_exp(7'h23, 32'd0, "R2 ctr3 not enabled");

        // R9 software increment
        wr(7'h07, 32'h0000_000F);
        rd_exp(7'h22, 32'd1, "R9 sw counter");
        rd_exp(7'h20, 32'd3, "R9 non-sw counter");

        // R2 global disable
        wr(7'h00, 32'h0);
        pulse(8'h04, 2);
        rd_exp(7'h20, 32'd3, "R2 global disable");
        wr(7'h00, 32'h1);

        // R3 wrap and R7 interrupt
        wr(7'h20, 32'hFFFF_FFFE);
        pulse(8'h04, 2);
        rd_exp(7'h20, 32'd0, "R3 wrapped value");
        rd_exp(7'h05, 32'h0000_0001, "R3 overflow flag");
        chk("R7 masked irq", {31'd0, irq}, 32'd0);
        wr(7'h03, 32'h1);
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        wr(7'h06, 32'h1);
        chk("R7 irq dropped by clear", {31'd0, irq}, 32'd0);
        wr(7'h05, 32'h1);
        chk("R7 irq raised by set", {31'd0, irq}, 32'd1);
        wr(7'h04, 32'h1);
        chk("R7 irq dropped by disable", {31'd0, irq}, 32'd0);
        wr(7'h06, 32'h1);
        wr(7'h05, 32'h0000_0F00);
        rd_exp(7'h05, 32'h0, "R6 absent overflow bits");

        // R4 event reset keeps cycle counter
        ticks(5);
        rd_exp(7'h3F, 32'd5, "R5 cycle ticks");
        pulse(8'h05, 1);
        wr(7'h00, 32'h3);
        rd_exp(7'h20, 32'd0, "R4 ctr0 cleared");
        rd_exp(7'h21, 32'd0, "R4 ctr1 cleared");
        rd_exp(7'h22, 32'd0, "R4 ctr2 cleared");
        rd_exp(7'h3F, 32'd5, "R4 cycle kept");

        // R5 cycle reset and divide
        wr(7'h00, 32'h5);
        rd_exp(7'h3F, 32'd0, "R5 cycle reset");
        ticks(10);
        rd_exp(7'h3F, 32'd10, "R5 cycle count");
        wr(7'h00, 32'hD);
        ticks(130);
        rd_exp(7'h3F, 32'd2, "R5 divide by 64");
        wr(7'h00, 32'h1);

        // R8 absent counters
        wr(7'h25, 32'd123);
        rd_exp(7'h25, 32'd0, "R8 absent value");
        wr(7'h47, 32'hFFFF_FFFF);
        rd_exp(7'h47, 32'd0, "R8 absent type");

        // R11 selection and indirect access
        wr(7'h08, 32'h0000_0023);
        rd_exp(7'h08, 32'd3, "R11 select low bits");
        wr(7'h09, 32'd77);
        rd_exp(7'h23, 32'd77, "R11 indirect value");
        wr(7'h08, 32'd31);
        wr(7'h0A, 32'h0400_0000);
        rd_exp(7'h5F, 32'h0400_0000, "R11 indirect cycle filter");
        rd_model(7'h09, "R11 indirect cycle value");

        // R12 write wins over same-cycle increment
        addr = 7'h21; wdata = 32'd10; we = 1'b1; evt = 8'h01;
        @(negedge clk);
        we = 1'b0; evt = '0;
        rd_exp(7'h21, 32'd10, "R12 write priority");
        pulse(8'h01, 1);
        rd_exp(7'h21, 32'd11, "R12 count after load");

        @(negedge clk);
        finish_run();
    end

endmodule